// File: doc/BRIEF.md
# SDRAM Low-Power State Sequencer

This block decides when an attached DDR-class memory goes into a low-power state and when it comes back out. It watches a transaction-pending flag and runs three idle counters, one each for power-down, self-refresh and clock stop. Each counter has its own programmable threshold, and a threshold of zero turns that automatic feature off. Self-refresh has three possible triggers: an idle timeout, a level request from software, and a request/acknowledge handshake from a hardware power manager.

The block asks a downstream command arbiter to issue the DRAM commands it needs. These are power-down entry, power-down exit, self-refresh entry, self-refresh exit and a long ZQ calibration. Each request is held until the arbiter accepts it. The block also drives the clock-enable level and a memory clock-stop control.

A single state machine sequences these moves, so only one low-power state is active at a time. A self-refresh request that arrives during power-down first takes the memory out of power-down. On DDR3 and LPDDR memories, every self-refresh exit is followed by a long ZQ calibration before the block returns to normal operation.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: While reset is held, and on release, cke is 1, clk_stop is 0, cmd_valid is 0, hw_lp_ack is 0 and hw_lp_deny is 0.
- R2: Power-down entry (cmd_code 1) is presented at the (cfg_pd_idle+1)-th rising edge after txn_pending goes low. Once it is accepted, cke is 0. A new transaction then presents power-down exit (cmd_code 2) at the next edge, and cke returns to 1 once that exit is accepted.
- R3: A threshold of zero disables its automatic feature. With all three thresholds at zero, an idle bus produces no command and no clock stop, even after the idle counters saturate.
- R4: With self-refresh enabled, self-refresh entry (cmd_code 3) is presented at the (cfg_sr_idle+1)-th edge of idleness. cke stays 0 while idle. The first transaction presents self-refresh exit (cmd_code 4).
- R5: The mode select cfg_mem_kind takes 0 for DDR2, 1 for DDR3 and 2 for LPDDR. For DDR3 and LPDDR, a long ZQ calibration (cmd_code 5) is presented on the edge after self-refresh exit is accepted. For DDR2 no ZQ command follows, and cke returns to 1 directly.
- R6: A high sw_sr_req, with no pending transaction, presents self-refresh entry at the next edge. The memory then stays in self-refresh while transactions arrive, and self-refresh exit is presented once sw_sr_req falls.
- R7: hw_lp_ack rises only after self-refresh entry has been accepted. When hw_lp_req falls, hw_lp_ack falls and self-refresh exit is presented on the same edge.
- R8: When cfg_sr_en is 0, a hardware request is answered by hw_lp_deny = 1 and never by an acknowledge or a command. hw_lp_deny clears one edge after the request drops.
- R9: Clock stop happens only when cfg_mem_kind selects LPDDR. In that case clk_stop rises at the (cfg_cs_idle+1)-th idle edge with cke held at 1 and no command issued, and clk_stop falls on the edge after a transaction arrives.
- R10: A self-refresh request made during power-down presents power-down exit first, and then self-refresh entry two edges later.
- R11: While cmd_ready is 0, cmd_valid and cmd_code hold steady, and the machine does not advance.
- R12: Each idle counter restarts on any pending transaction, so a single busy cycle restarts the power-down count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mem_kind | input | 2 | Memory family: 0 DDR2, 1 DDR3, 2 or 3 LPDDR |
| cfg_sr_en | input | 1 | Enables self-refresh for all three triggers |
| cfg_pd_idle | input | CNT_W | Idle cycles before power-down, 0 disables it |
| cfg_sr_idle | input | CNT_W | Idle cycles before automatic self-refresh, 0 disables it |
| cfg_cs_idle | input | CNT_W | Idle cycles before clock stop, 0 disables it |
| txn_pending | input | 1 | A transaction is waiting in the controller |
| sw_sr_req | input | 1 | Software self-refresh request (level) |
| hw_lp_req | input | 1 | Hardware low-power request (level) |
| hw_lp_ack | output | 1 | Hardware request granted; memory is in self-refresh |
| hw_lp_deny | output | 1 | Hardware request refused because self-refresh is disabled |
| cmd_valid | output | 1 | Command request to the arbiter |
| cmd_code | output | 3 | 1 PDE, 2 PDX, 3 SRE, 4 SRX, 5 ZQ long |
| cmd_ready | input | 1 | Arbiter accepts the command this cycle |
| cke | output | 1 | Clock-enable level toward the memory |
| clk_stop | output | 1 | Stop the memory clock |

## Verification
The bench builds the block with CNT_W = 6. This keeps the counter ceiling at 63, so the zero-threshold run can idle past saturation within a few dozen cycles. The thresholds used stay between 2 and 5, which lets the bench check the exact edge of each automatic entry and the restart caused by a one-cycle transaction. A stalled arbiter, a request made during power-down, and all three memory families are each driven directly.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [3:0] {
    ST_ACTIVE,
    ST_PD_ENTRY,
    ST_POWERDOWN,
    ST_PD_EXIT,
    ST_SR_ENTRY,
    ST_SELFREF,
    ST_SR_EXIT,
    ST_ZQL,
    ST_CLKSTOP
  } lps_state_e;

  typedef enum logic [1:0] {
    SRC_AUTO,
    SRC_SW,
    SRC_HW
  } sr_src_e;

  localparam logic [2:0] CMD_NONE = 3'd0;
  localparam logic [2:0] CMD_PDE  = 3'd1;
  localparam logic [2:0] CMD_PDX  = 3'd2;
  localparam logic [2:0] CMD_SRE  = 3'd3;
  localparam logic [2:0] CMD_SRX  = 3'd4;
  localparam logic [2:0] CMD_ZQL  = 3'd5;

  localparam logic [1:0] MEM_DDR2  = 2'd0;
  localparam logic [1:0] MEM_DDR3  = 2'd1;
  localparam logic [1:0] MEM_LPDDR = 2'd2;

  localparam int TMR_PD  = 0;
  localparam int TMR_SR  = 1;
  localparam int TMR_CS  = 2;
  localparam int NUM_TMR = 3;

  function automatic logic kind_is_lpddr(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic kind_needs_zq(input logic [1:0] kind);
    return kind != MEM_DDR2;
  endfunction

endpackage

// File: rtl/lps_rst_sync.sv
module lps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/lps_idle_timer.sv
module lps_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] thresh,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Saturating count of consecutive idle cycles; restart on clear.
  always_comb begin
    cnt_en = clear | (cnt_q != CNT_MAX);
    cnt_d  = clear ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (thresh != '0) && (cnt_q >= thresh);

endmodule

// File: rtl/lps_hw_handshake.sv
module lps_hw_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_req,
  input  logic sr_en,
  input  logic sr_hw_held,
  output logic hw_ack,
  output logic hw_deny
);

  logic ack_q, ack_d;
  logic deny_q, deny_d;

  always_comb begin
    ack_d  = sr_hw_held & hw_req;
    deny_d = hw_req & ~sr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      deny_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      deny_q <= deny_d;
    end
  end

  assign hw_ack  = ack_q;
  assign hw_deny = deny_q;

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_pending,
  input  logic       sw_req,
  input  logic       hw_req,
  input  logic       sr_en,
  input  logic       pd_exp,
  input  logic       sr_exp,
  input  logic       cs_exp,
  input  logic       clk_stop_ok,
  input  logic       zq_after_sr,
  input  logic       cmd_ready,
  output logic       cmd_valid,
  output logic [2:0] cmd_code,
  output logic       cke,
  output logic       clk_stop,
  output logic       sr_hw_held,
  output logic       sr_exiting
);

  lps_state_e state_q, state_d;
  sr_src_e    src_q, src_d;

  logic want_sw, want_hw, want_auto, want_any;
  logic sr_release;

  always_comb begin
    want_sw   = sr_en & sw_req;
    want_hw   = sr_en & hw_req;
    want_auto = sr_en & sr_exp;
    want_any  = want_sw | want_hw | want_auto;
    unique case (src_q)
      SRC_SW:  sr_release = ~sw_req;
      SRC_HW:  sr_release = ~hw_req;
      default: sr_release = txn_pending;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (!txn_pending) begin
          if (want_sw) begin
            state_d = ST_SR_ENTRY;
            src_d   = SRC_SW;
          end else if (want_hw) begin
            state_d = ST_SR_ENTRY;
            src_d   = SRC_HW;
          end else if (want_auto) begin
            state_d = ST_SR_ENTRY;
            src_d   = SRC_AUTO;
          end else if (pd_exp) begin
            state_d = ST_PD_ENTRY;
          end else if (cs_exp && clk_stop_ok) begin
            state_d = ST_CLKSTOP;
          end
        end
      end
      ST_PD_ENTRY: begin
        if (cmd_ready) state_d = ST_POWERDOWN;
      end
      ST_POWERDOWN: begin
        if (txn_pending || want_any) state_d = ST_PD_EXIT;
      end
      ST_PD_EXIT: begin
        if (cmd_ready) state_d = ST_ACTIVE;
      end
      ST_SR_ENTRY: begin
        if (cmd_ready) state_d = ST_SELFREF;
      end
      ST_SELFREF: begin
        if (sr_release) state_d = ST_SR_EXIT;
      end
      ST_SR_EXIT: begin
        if (cmd_ready) state_d = zq_after_sr ? ST_ZQL : ST_ACTIVE;
      end
      ST_ZQL: begin
        if (cmd_ready) state_d = ST_ACTIVE;
      end
      ST_CLKSTOP: begin
        if (txn_pending || want_any || pd_exp) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      src_q   <= SRC_AUTO;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
    end
  end

  // Moore outputs
  always_comb begin
    cmd_valid = 1'b1;
    cmd_code  = CMD_NONE;
    unique case (state_q)
      ST_PD_ENTRY: cmd_code = CMD_PDE;
      ST_PD_EXIT:  cmd_code = CMD_PDX;
      ST_SR_ENTRY: cmd_code = CMD_SRE;
      ST_SR_EXIT:  cmd_code = CMD_SRX;
      ST_ZQL:      cmd_code = CMD_ZQL;
      default:     cmd_valid = 1'b0;
    endcase
    cke        = !(state_q inside {ST_POWERDOWN, ST_PD_EXIT, ST_SELFREF, ST_SR_EXIT});
    clk_stop   = (state_q == ST_CLKSTOP);
    sr_hw_held = (state_q == ST_SELFREF) && (src_q == SRC_HW);
    sr_exiting = (state_q == ST_SR_EXIT);
  end

endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
  import lps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mem_kind,
  input  logic             cfg_sr_en,
  input  logic [CNT_W-1:0] cfg_pd_idle,
  input  logic [CNT_W-1:0] cfg_sr_idle,
  input  logic [CNT_W-1:0] cfg_cs_idle,
  input  logic             txn_pending,
  input  logic             sw_sr_req,
  input  logic             hw_lp_req,
  output logic             hw_lp_ack,
  output logic             hw_lp_deny,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  input  logic             cmd_ready,
  output logic             cke,
  output logic             clk_stop
);

  logic rst_sync_n;
  logic tmr_clear;
  logic sr_hw_held;
  logic sr_exiting;
  logic [NUM_TMR-1:0]            tmr_exp;
  logic [NUM_TMR-1:0][CNT_W-1:0] tmr_thr;

  lps_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  always_comb begin
    tmr_thr[TMR_PD] = cfg_pd_idle;
    tmr_thr[TMR_SR] = cfg_sr_idle;
    tmr_thr[TMR_CS] = cfg_cs_idle;
    tmr_clear       = txn_pending | sr_exiting;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    lps_idle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clear   (tmr_clear),
      .thresh  (tmr_thr[g]),
      .expired (tmr_exp[g])
    );
  end

  lps_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .txn_pending (txn_pending),
    .sw_req      (sw_sr_req),
    .hw_req      (hw_lp_req),
    .sr_en       (cfg_sr_en),
    .pd_exp      (tmr_exp[TMR_PD]),
    .sr_exp      (tmr_exp[TMR_SR]),
    .cs_exp      (tmr_exp[TMR_CS]),
    .clk_stop_ok (kind_is_lpddr(cfg_mem_kind)),
    .zq_after_sr (kind_needs_zq(cfg_mem_kind)),
    .cmd_ready   (cmd_ready),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cke         (cke),
    .clk_stop    (clk_stop),
    .sr_hw_held  (sr_hw_held),
    .sr_exiting  (sr_exiting)
  );

  lps_hw_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hw_req     (hw_lp_req),
    .sr_en      (cfg_sr_en),
    .sr_hw_held (sr_hw_held),
    .hw_ack     (hw_lp_ack),
    .hw_deny    (hw_lp_deny)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker
  import lps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mem_kind,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       cmd_ready,
  input logic       cke,
  input logic       clk_stop,
  input logic       hw_lp_ack
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code))); // R11

  AST_CKE_FALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(cmd_valid && cmd_ready)); // R2

  AST_CKE_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(cmd_valid && cmd_ready)); // R4

  AST_ZQ_NOT_DDR2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_ZQL) |-> (cfg_mem_kind != MEM_DDR2)); // R5

  AST_ACK_IN_SELFREF: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lp_ack |-> !cke); // R7

  AST_CLKSTOP_LPDDR: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> (kind_is_lpddr(cfg_mem_kind) && cke && !cmd_valid)); // R9

endmodule

bind sdram_lp_sequencer lps_checker u_lps_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mem_kind (cfg_mem_kind),
  .cmd_valid    (cmd_valid),
  .cmd_code     (cmd_code),
  .cmd_ready    (cmd_ready),
  .cke          (cke),
  .clk_stop     (clk_stop),
  .hw_lp_ack    (hw_lp_ack)
);

// File: tb/sdram_lp_sequencer_bench.sv
`timescale 1ns/1ps
module sdram_lp_sequencer_bench;

  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       cfg_mem_kind;
  logic             cfg_sr_en;
  logic [CNT_W-1:0] cfg_pd_idle, cfg_sr_idle, cfg_cs_idle;
  logic             txn_pending, sw_sr_req, hw_lp_req, cmd_ready;
  logic             hw_lp_ack, hw_lp_deny, cmd_valid, cke, clk_stop;
  logic [2:0]       cmd_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sdram_lp_sequencer #(.CNT_W(CNT_W)) u_sdram_lp_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_mem_kind(cfg_mem_kind), .cfg_sr_en(cfg_sr_en),
    .cfg_pd_idle(cfg_pd_idle), .cfg_sr_idle(cfg_sr_idle), .cfg_cs_idle(cfg_cs_idle),
    .txn_pending(txn_pending), .sw_sr_req(sw_sr_req), .hw_lp_req(hw_lp_req),
    .hw_lp_ack(hw_lp_ack), .hw_lp_deny(hw_lp_deny), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ready(cmd_ready), .cke(cke), .clk_stop(clk_stop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Wait up to maxc edges for a command; n = edges taken, 0 if none.
  task automatic wait_cmd(input int maxc, output int n, output int code);
    n = 0;
    code = 0;
    for (int i = 1; i <= maxc; i++) begin
      tick();
      if (cmd_valid) begin
        n = i;
        code = cmd_code;
        break;
      end
    end
  endtask

  task automatic settle();
    @(negedge clk);
    txn_pending = 1'b1;
    sw_sr_req   = 1'b0;
    hw_lp_req   = 1'b0;
    cmd_ready   = 1'b1;
    cfg_sr_en   = 1'b1;
    cfg_pd_idle = '0;
    cfg_sr_idle = '0;
    cfg_cs_idle = '0;
    repeat (6) tick();
  endtask

  task automatic t_reset();
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(clk_stop == 1'b0, "R1 clk_stop", clk_stop, 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    chk(hw_lp_ack == 1'b0 && hw_lp_deny == 1'b0, "R1 ack/deny", hw_lp_ack + hw_lp_deny, 0);
  endtask

  task automatic t_powerdown();
    int n, c;
    settle();
    cfg_mem_kind = 2'd1;
    cfg_pd_idle  = 6'd5;
    @(negedge clk) txn_pending = 1'b0;
    repeat (3) tick();
    @(negedge clk) txn_pending = 1'b1;
    @(negedge clk) txn_pending = 1'b0;
    wait_cmd(12, n, c);
    chk(n == 6, "R12 restart after busy cycle", n, 6);
    chk(c == 1, "R2 PDE code", c, 1);
    tick();
    chk(cke == 1'b0, "R2 cke low in power-down", cke, 0);
    @(negedge clk) txn_pending = 1'b1;
    wait_cmd(3, n, c);
    chk(n == 1 && c == 2, "R2 PDX on traffic", c, 2);
    tick();
    chk(cke == 1'b1, "R2 cke back high", cke, 1);
  endtask

  task automatic t_zero();
    int ncmd = 0, ncs = 0, nlow = 0;
    settle();
    cfg_mem_kind = 2'd2;
    @(negedge clk) txn_pending = 1'b0;
    for (int i = 0; i < 80; i++) begin
      tick();
      if (cmd_valid) ncmd++;
      if (clk_stop) ncs++;
      if (!cke) nlow++;
    end
    chk(ncmd == 0, "R3 no command with zero thresholds", ncmd, 0);
    chk(ncs + nlow == 0, "R3 no clock stop or cke drop", ncs + nlow, 0);
  endtask

  task automatic t_auto_sr(input logic [1:0] kind);
    int n, c, bad = 0;
    settle();
    cfg_mem_kind = kind;
    cfg_sr_idle  = 6'd4;
    @(negedge clk) txn_pending = 1'b0;
    wait_cmd(10, n, c);
    chk(n == 5 && c == 3, "R4 SRE after idle", n, 5);
    for (int i = 0; i < 8; i++) begin
      tick();
      if (cmd_valid || cke) bad++;
    end
    chk(bad == 0, "R4 stays in self-refresh", bad, 0);
    @(negedge clk) txn_pending = 1'b1;
    wait_cmd(3, n, c);
    chk(n == 1 && c == 4, "R4 SRX on traffic", c, 4);
    if (kind == 2'd0) begin
      wait_cmd(4, n, c);
      chk(n == 0, "R5 no ZQ for DDR2", c, 0);
      chk(cke == 1'b1, "R5 DDR2 back active", cke, 1);
    end else begin
      wait_cmd(3, n, c);
      chk(n == 1 && c == 5, "R5 ZQ long after SRX", c, 5);
      tick();
      chk(cke == 1'b1 && !cmd_valid, "R5 active after ZQ", cke, 1);
    end
  endtask

  task automatic t_sw();
    int n, c, bad = 0;
    settle();
    cfg_mem_kind = 2'd2;
    @(negedge clk) begin
      txn_pending = 1'b0;
      sw_sr_req   = 1'b1;
    end
    wait_cmd(4, n, c);
    chk(n == 1 && c == 3, "R6 SRE on software request", n, 1);
    @(negedge clk) txn_pending = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (cmd_valid || cke) bad++;
    end
    chk(bad == 0, "R6 traffic does not end software self-refresh", bad, 0);
    @(negedge clk) sw_sr_req = 1'b0;
    wait_cmd(3, n, c);
    chk(n == 1 && c == 4, "R6 SRX on release", c, 4);
    wait_cmd(3, n, c);
    chk(c == 5, "R5 ZQ long for LPDDR", c, 5);
  endtask

  task automatic t_hw();
    int n, c;
    settle();
    cfg_mem_kind = 2'd1;
    @(negedge clk) begin
      txn_pending = 1'b0;
      hw_lp_req   = 1'b1;
    end
    wait_cmd(4, n, c);
    chk(n == 1 && c == 3, "R7 SRE on hardware request", c, 3);
    chk(hw_lp_ack == 1'b0, "R7 no ack before SRE accepted", hw_lp_ack, 0);
    repeat (2) tick();
    chk(hw_lp_ack == 1'b1, "R7 ack after SRE", hw_lp_ack, 1);
    @(negedge clk) hw_lp_req = 1'b0;
    tick();
    chk(cmd_valid && cmd_code == 3'd4, "R7 SRX on request drop", cmd_code, 4);
    chk(hw_lp_ack == 1'b0, "R7 ack drops", hw_lp_ack, 1'b0);
  endtask

  task automatic t_deny();
    int ncmd = 0;
    settle();
    cfg_sr_en = 1'b0;
    @(negedge clk) begin
      txn_pending = 1'b0;
      hw_lp_req   = 1'b1;
    end
    for (int i = 0; i < 10; i++) begin
      tick();
      if (cmd_valid) ncmd++;
    end
    chk(ncmd == 0, "R8 no command when disabled", ncmd, 0);
    chk(hw_lp_deny == 1'b1 && hw_lp_ack == 1'b0, "R8 deny raised", hw_lp_deny, 1);
    @(negedge clk) hw_lp_req = 1'b0;
    tick();
    chk(hw_lp_deny == 1'b0, "R8 deny clears", hw_lp_deny, 0);
  endtask

  task automatic t_clkstop();
    int n = 0, ncmd = 0, ncs = 0;
    settle();
    cfg_mem_kind = 2'd2;
    cfg_cs_idle  = 6'd3;
    @(negedge clk) txn_pending = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      tick();
      if (cmd_valid) ncmd++;
      if (clk_stop) begin
        n = i;
        break;
      end
    end
    chk(n == 4 && ncmd == 0, "R9 clock stop edge", n, 4);
    chk(cke == 1'b1, "R9 cke high in clock stop", cke, 1);
    @(negedge clk) txn_pending = 1'b1;
    tick();
    chk(clk_stop == 1'b0, "R9 clock restarts", clk_stop, 0);
    settle();
    cfg_mem_kind = 2'd1;
    cfg_cs_idle  = 6'd3;
    @(negedge clk) txn_pending = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (clk_stop) ncs++;
    end
    chk(ncs == 0, "R9 no clock stop on DDR3", ncs, 0);
  endtask

  task automatic t_pd_then_sr();
    int n, c;
    settle();
    cfg_mem_kind = 2'd1;
    cfg_pd_idle  = 6'd3;
    @(negedge clk) txn_pending = 1'b0;
    wait_cmd(8, n, c);
    chk(n == 4 && c == 1, "R10 PDE first", n, 4);
    repeat (3) tick();
    @(negedge clk) sw_sr_req = 1'b1;
    wait_cmd(3, n, c);
    chk(n == 1 && c == 2, "R10 PDX before self-refresh", c, 2);
    wait_cmd(4, n, c);
    chk(n == 2 && c == 3, "R10 SRE after PDX", n, 2);
    @(negedge clk) txn_pending = 1'b1;
    @(negedge clk) sw_sr_req = 1'b0;
    wait_cmd(3, n, c);
    chk(c == 4, "R10 SRX on release", c, 4);
  endtask

  task automatic t_hold();
    int n, c, bad = 0;
    settle();
    cfg_mem_kind = 2'd1;
    cfg_pd_idle  = 6'd2;
    cmd_ready    = 1'b0;
    @(negedge clk) txn_pending = 1'b0;
    wait_cmd(6, n, c);
    chk(n == 3 && c == 1, "R11 PDE presented", n, 3);
    for (int i = 0; i < 4; i++) begin
      tick();
      if (!cmd_valid || cmd_code != 3'd1 || !cke) bad++;
    end
    chk(bad == 0, "R11 held while not ready", bad, 0);
    @(negedge clk) cmd_ready = 1'b1;
    tick();
    chk(!cmd_valid && !cke, "R11 advances on ready", cmd_valid, 0);
    @(negedge clk) txn_pending = 1'b1;
    wait_cmd(3, n, c);
    chk(c == 2, "R2 PDX after held entry", c, 2);
  endtask

  initial begin
    rst_n        = 1'b0;
    cfg_mem_kind = 2'd1;
    cfg_sr_en    = 1'b1;
    cfg_pd_idle  = '0;
    cfg_sr_idle  = '0;
    cfg_cs_idle  = '0;
    txn_pending  = 1'b1;
    sw_sr_req    = 1'b0;
    hw_lp_req    = 1'b0;
    cmd_ready    = 1'b1;
    repeat (3) tick();
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_powerdown();
    t_zero();
    t_auto_sr(2'd1);
    t_auto_sr(2'd0);
    t_sw();
    t_hw();
    t_deny();
    t_clkstop();
    t_pd_then_sr();
    t_hold();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule